// File: doc/BRIEF.md
# Hex Record Stream Loader

This block takes in a stream of ASCII characters that carry text-format hex records and loads the data they describe into a byte-wide memory. One character can be offered per cycle on a valid/ready input, and the block takes every character offered. Inside each record, every byte is two hex digits with the high nibble first. The block decodes the length, the start address, the record type, the payload bytes and the closing checksum. It writes each payload byte to the memory port as soon as the byte is complete, at consecutive addresses that start from the record address.

A closing record with a correct checksum stops the loader. After it, `done` stays high and all further input is thrown away. A malformed record raises a sticky `err` flag and the rest of that record is discarded: a bad digit, a length that is too large, an unknown type or a wrong checksum all count as malformed. The parser then waits for the next record's leading colon. Bytes that were already written from a record that later fails its checksum stay in memory. A system controller watches `err` to decide whether to trust the image.

Top module: `hexld_top`

## Requirements
- R1: An active-high synchronous reset puts the parser in the state where it looks for a colon, and drives `done`, `err` and `mem_we` low.
- R2: `in_ready` is always high. A character is taken only in a cycle where `in_valid` is high. Outside a record, every character other than `:` (0x3A) is skipped, including CR and LF, and causes no write and no error.
- R3: Each byte in a record is two ASCII hex digits, high nibble first. The digits `0`-`9`, `A`-`F` and `a`-`f` are accepted.
- R4: After the colon, the fields arrive in this order: one count byte, two address bytes (high byte first), one type byte, as many data bytes as the count gives, and one checksum byte.
- R5: Each data byte causes exactly one `mem_we` pulse. The pulse is registered and appears in the cycle after the byte's second digit is taken. Data byte k of a record is written to the record address plus k, modulo 2^16.
- R6: A record is valid when the 8-bit sum of all its bytes, checksum included, is zero. Otherwise `err` goes high. `err` stays high until reset.
- R7: A count above 0x10, or a type other than 0x00 (data) or 0x01 (end), sets `err`. The record is then dropped with no write, and the parser goes back to looking for a colon.
- R8: Any character other than a hex digit inside a record sets `err` and abandons the record. This includes a colon.
- R9: An end record (type 0x01) with a valid checksum raises `done`. `done` stays high until reset, and all characters after it cause no write. An end record with a bad checksum does not raise `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | Character accepted (always high) |
| in_char | input | 8 | ASCII character |
| mem_we | output | 1 | Memory write strobe, one cycle per data byte |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | End record loaded, held until reset |
| err | output | 1 | A malformed record was seen, held until reset |

## Verification
The bench sends a data record for every count from 0 to 16, mixing digit case and leaving idle gaps between characters. A design that miscounts the payload would write one byte too many or too few, and one that decodes lower-case digits wrongly would write the wrong data. Further records start just below the top of the address space, carry noise and line breaks before the colon, break the checksum, overrun the count limit, use an unknown type or contain a bad digit. The goal is to catch an address that saturates instead of wrapping, a checksum taken over the data alone, or writes that leak out of a record that was rejected. End records are sent with good and bad checksums and are followed by more traffic. This exposes a loader that finishes on a corrupt end record or keeps writing after it has stopped.

// File: rtl/hexld_pkg.sv
package hexld_pkg;
    typedef enum logic [2:0] {
        PH_HUNT,
        PH_COUNT,
        PH_ADDR,
        PH_TYPE,
        PH_DATA,
        PH_SUM,
        PH_HALT
    } phase_e;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] TYPE_DATA = 8'h00;
    localparam logic [7:0] TYPE_END = 8'h01;
endpackage

// File: rtl/hexld_nib_dec.sv
module hexld_nib_dec (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    always_comb begin
        is_hex = 1'b1;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            nib = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            nib = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            nib = 4'(ch - 8'h57);
        end else begin
            is_hex = 1'b0;
        end
    end
endmodule

// File: rtl/hexld_core.sv
module hexld_core
    import hexld_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int MAX_CNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    input  logic              dig_ok,
    input  logic [3:0]        dig_val,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic              err
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int LEFT_W     = $clog2(MAX_CNT + 1);

    typedef struct packed {
        phase_e              phase;
        logic                have_hi;
        logic [3:0]          hi_nib;
        logic [IDX_W-1:0]    idx;
        logic [7:0]          cnt;
        logic [LEFT_W-1:0]   left;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          rtype;
        logic [7:0]          sum;
        logic                we;
        logic [ADDR_W-1:0]   waddr;
        logic [7:0]          wdata;
        logic                done;
        logic                err;
    } core_state_s;

    core_state_s st_q, st_d;
    logic [7:0]  byte_v;
    logic [7:0]  sum_v;

    assign byte_v = {st_q.hi_nib, dig_val};
    assign sum_v  = st_q.sum + byte_v;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (in_valid) begin
            case (st_q.phase)
                PH_HUNT: begin
                    if (in_char == CH_COLON) begin
                        st_d.phase   = PH_COUNT;
                        st_d.have_hi = 1'b0;
                        st_d.sum     = 8'h00;
                        st_d.idx     = '0;
                    end
                end
                PH_HALT: begin
                end
                default: begin
                    if (!dig_ok) begin
                        st_d.err   = 1'b1;
                        st_d.phase = PH_HUNT;
                    end else if (!st_q.have_hi) begin
                        st_d.have_hi = 1'b1;
                        st_d.hi_nib  = dig_val;
                    end else begin
                        st_d.have_hi = 1'b0;
                        st_d.sum     = sum_v;
                        case (st_q.phase)
                            PH_COUNT: begin
                                st_d.cnt = byte_v;
                                if (byte_v > 8'(MAX_CNT)) begin
                                    st_d.err   = 1'b1;
                                    st_d.phase = PH_HUNT;
                                end else begin
                                    st_d.phase = PH_ADDR;
                                end
                            end
                            PH_ADDR: begin
                                st_d.addr = {st_q.addr[ADDR_W-9:0], byte_v};
                                if (st_q.idx == IDX_W'(ADDR_BYTES - 1)) begin
                                    st_d.phase = PH_TYPE;
                                end else begin
                                    st_d.idx = st_q.idx + 1'b1;
                                end
                            end
                            PH_TYPE: begin
                                st_d.rtype = byte_v;
                                st_d.left  = LEFT_W'(st_q.cnt);
                                if (byte_v != TYPE_DATA && byte_v != TYPE_END) begin
                                    st_d.err   = 1'b1;
                                    st_d.phase = PH_HUNT;
                                end else if (st_q.cnt == 8'h00) begin
                                    st_d.phase = PH_SUM;
                                end else begin
                                    st_d.phase = PH_DATA;
                                end
                            end
                            PH_DATA: begin
                                st_d.we    = 1'b1;
                                st_d.wdata = byte_v;
                                st_d.waddr = st_q.addr;
                                st_d.addr  = st_q.addr + 1'b1;
                                st_d.left  = st_q.left - 1'b1;
                                if (st_q.left == LEFT_W'(1)) begin
                                    st_d.phase = PH_SUM;
                                end
                            end
                            PH_SUM: begin
                                if (sum_v != 8'h00) begin
                                    st_d.err   = 1'b1;
                                    st_d.phase = PH_HUNT;
                                end else if (st_q.rtype == TYPE_END) begin
                                    st_d.done  = 1'b1;
                                    st_d.phase = PH_HALT;
                                end else begin
                                    st_d.phase = PH_HUNT;
                                end
                            end
                            default: st_d.phase = PH_HUNT;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.phase <= PH_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.waddr;
    assign mem_wdata = st_q.wdata;
    assign done      = st_q.done;
    assign err       = st_q.err;

    // R5
    we_follows_char_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(in_valid));

    // R9
    done_held_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R6
    err_held_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9
    no_write_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we, 2) && st_q.phase == PH_DATA && !$past(dig_ok == 1'b0))
        |-> (mem_addr == $past(mem_addr, 2) + 1'b1));
endmodule

// File: rtl/hexld_top.sv
module hexld_top #(
    parameter int ADDR_W  = 16,
    parameter int MAX_CNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_char,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic              err
);
    logic       dig_ok;
    logic [3:0] dig_val;

    assign in_ready = 1'b1;

    hexld_nib_dec u_dec (
        .ch     (in_char),
        .is_hex (dig_ok),
        .nib    (dig_val)
    );

    hexld_core #(
        .ADDR_W  (ADDR_W),
        .MAX_CNT (MAX_CNT)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_char   (in_char),
        .dig_ok    (dig_ok),
        .dig_val   (dig_val),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .err       (err)
    );
endmodule

// File: tb/hexld_top_tb.sv
module hexld_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_char = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;

    logic [7:0]  tx [0:31];
    logic [15:0] log_a [0:63];
    logic [7:0]  log_d [0:63];
    int          wcount = 0;
    bit          gappy = 0;

    always #10 clk = ~clk;

    hexld_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_char(in_char), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .err(err)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            if (wcount < 64) begin
                log_a[wcount] = mem_addr;
                log_d[wcount] = mem_wdata;
            end
            wcount = wcount + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    task automatic put(input logic [7:0] c);
        in_valid = 1'b1;
        in_char  = c;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (gappy) begin
            @(negedge clk);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input bit lower);
        put(hexc(b[7:4], lower));
        put(hexc(b[3:0], lower));
    endtask

    task automatic send_rec(input logic [7:0] cnt, input logic [15:0] addr,
                            input logic [7:0] typ, input int ndata,
                            input bit lower, input logic [7:0] corrupt);
        int s;
        s = int'(cnt) + int'(addr[15:8]) + int'(addr[7:0]) + int'(typ);
        put(8'h3A);
        put_byte(cnt, lower);
        put_byte(addr[15:8], lower);
        put_byte(addr[7:0], lower);
        put_byte(typ, lower);
        for (int i = 0; i < ndata; i++) begin
            s = s + int'(tx[i]);
            put_byte(tx[i], lower);
        end
        put_byte(8'((256 - (s % 256)) % 256) ^ corrupt, lower);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_writes(input int n, input logic [15:0] base, input string req);
        chk(wcount == n, req, wcount, n);
        for (int i = 0; i < n && i < 64; i++) begin
            chk(log_a[i] == base + 16'(i), req, log_a[i], base + 16'(i));
            chk(log_d[i] == tx[i], req, log_d[i], tx[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && err == 1'b0 && mem_we == 1'b0, "R1", {done, err, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R2 ready always high
        chk(in_ready == 1'b1, "R2", in_ready, 1);

        // R3 R4 R5: sweep counts 0..16, both digit cases, with and without gaps
        for (int n = 0; n <= 16; n++) begin
            base  = 16'h1200 + 16'(n * 37);
            gappy = (n % 3 == 0);
            for (int i = 0; i < n; i++) tx[i] = 8'((n * 13 + i * 7 + 1) & 255);
            if (n > 0) tx[0] = 8'hAF;
            wcount = 0;
            send_rec(8'(n), base, 8'h00, n, (n % 2) == 1, 8'h00);
            check_writes(n, base, "R5");
            chk(err == 1'b0, "R3", err, 0);
        end
        gappy = 0;

        // R5 address wrap
        for (int i = 0; i < 4; i++) tx[i] = 8'h50 + 8'(i);
        wcount = 0;
        send_rec(8'h04, 16'hFFFE, 8'h00, 4, 0, 8'h00);
        check_writes(4, 16'hFFFE, "R5");

        // R2 noise and line breaks before colon
        put(8'h78); put(8'h0D); put(8'h0A); put(8'h41); put(8'h30);
        for (int i = 0; i < 2; i++) tx[i] = 8'hC3 + 8'(i);
        wcount = 0;
        send_rec(8'h02, 16'h0040, 8'h00, 2, 0, 8'h00);
        check_writes(2, 16'h0040, "R2");
        chk(err == 1'b0, "R2", err, 0);

        // R6 bad checksum
        tx[0] = 8'h11;
        send_rec(8'h01, 16'h0300, 8'h00, 1, 0, 8'h01);
        chk(err == 1'b1, "R6", err, 1);
        chk(done == 1'b0, "R6", done, 0);
        do_reset();
        chk(err == 1'b0 && done == 1'b0, "R1", {err, done}, 0);

        // R7 count too large
        for (int i = 0; i < 17; i++) tx[i] = 8'(i);
        wcount = 0;
        send_rec(8'h11, 16'h0500, 8'h00, 17, 0, 8'h00);
        chk(wcount == 0, "R7", wcount, 0);
        chk(err == 1'b1, "R7", err, 1);
        do_reset();

        // R7 unknown type
        wcount = 0;
        send_rec(8'h02, 16'h0600, 8'h02, 2, 0, 8'h00);
        chk(wcount == 0, "R7", wcount, 0);
        chk(err == 1'b1, "R7", err, 1);
        do_reset();

        // R8 bad digit inside address
        wcount = 0;
        put(8'h3A); put(8'h30); put(8'h31); put(8'h31); put(8'h47);
        put(8'h30); put(8'h30); put(8'h30); put(8'h30); put(8'h35); put(8'h35); put(8'h30); put(8'h30);
        repeat (3) @(negedge clk);
        chk(wcount == 0, "R8", wcount, 0);
        chk(err == 1'b1, "R8", err, 1);
        do_reset();

        // R9 end record with bad checksum
        send_rec(8'h00, 16'h0000, 8'h01, 0, 0, 8'h80);
        chk(done == 1'b0, "R9", done, 0);
        chk(err == 1'b1, "R6", err, 1);
        do_reset();

        // R9 valid end record, then traffic is ignored
        send_rec(8'h00, 16'h0000, 8'h01, 0, 0, 8'h00);
        chk(done == 1'b1, "R9", done, 1);
        chk(err == 1'b0, "R9", err, 0);
        tx[0] = 8'h99;
        wcount = 0;
        send_rec(8'h01, 16'h0700, 8'h00, 1, 0, 8'h00);
        chk(wcount == 0, "R9", wcount, 0);
        chk(done == 1'b1, "R9", done, 1);
        do_reset();
        // R1 reset clears done
        chk(done == 1'b0, "R1", done, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule